// File: doc/BRIEF.md
# Multi-Line Reset Generator

This block drives a vector of independent, active-high reset outputs from a small set of memory-mapped registers. Software sets bits in a control register to start resets. Most lines are pulse lines. A pulse line stays asserted for a fixed number of clock cycles and then drops without any further write. A few lines are held lines. A held line stays asserted until software writes its control bit back to 0. By default the held lines are 12 and 56. Line 0 is the line that restarts the whole core, and it behaves as a pulse line.

Each line runs its own small state machine with three states. IDLE means the line is not asserted. PULSE means the line is asserted and its countdown is running. HELD means a held line is asserted. The transitions are:
- ARM: IDLE to PULSE, on a write of 1 to a pulse line.
- RETRIGGER: PULSE to PULSE, on a new write of 1, which reloads the count.
- EXPIRE: PULSE to IDLE, when the count runs out.
- LATCH: IDLE to HELD, on a write of 1 to a held line.
- RELEASE: HELD to IDLE, on a write of 0 to a held line.

Status registers report every line active-low. The bus is a plain synchronous register port. Read data is registered and appears one cycle after the read strobe.

Top module: `rst_line_gen`

## Requirements
- R1: When the synchronous reset `rst` is asserted, all outputs `rst_out` go to 0 on the next clock edge. A status read made after that returns all ones.
- R2: Line n belongs to control register n/32, at bit n%32. The control register for lines 0–31 is at byte address 0x100, and the one for lines 32–63 is at 0x104. A write of 1 to a bit asserts that line, and `rst_out` shows it after the clock edge that samples the write.
- R3: A write of 0 to a pulse line's bit has no effect. It does not assert an idle line, and it does not shorten a running pulse.
- R4: A pulse line stays asserted for exactly PULSE_CYCLES clock cycles (default 16) after the edge of the write, and then releases by itself.
- R5: A new write of 1 to a pulse line that is still asserted restarts its full PULSE_CYCLES count from that write's edge.
- R6: A held line stays asserted for as long as no write of 0 reaches its control bit, no matter how many cycles pass.
- R7: A write to a held line's control register that has 0 in that line's bit releases the line on that edge. A write that has 1 in that bit keeps the line asserted.
- R8: The status register for lines 0–31 is at 0x150, and the one for lines 32–63 is at 0x154. A status bit reads 0 while its line is asserted and 1 while the line is inactive. `bus_rdata` shows the state before the read edge, one cycle after `bus_re`.
- R9: A read of a control register returns 1 for each held line that is asserted, and 0 for every pulse line whatever its state.
- R10: An address that maps to no register ignores writes, and a read of it returns 0. `bus_rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rst_out | output | 64 | Reset outputs, 1 = asserted |

## Verification
The checker tests these rules on every cycle:
- After reset, all outputs are quiet.
- No line rises unless a write happened in the cycle before.
- A held line neither drops without a write to its register nor survives a write of 0.
- Line 0 never stays asserted longer than PULSE_CYCLES without a retrigger.
- Status read data is the inverse of the outputs one cycle earlier.

Some behaviour only the directed scenarios can show:
- The exact pulse length.
- The restart on retrigger.
- That writes of 0 neither shorten nor start a pulse.
- That unmapped addresses are ignored.
- How each line maps to its register and bit at the edges of the vector: lines 0, 31, 32 and 63.

// File: rtl/rgu_pkg.sv
package rgu_pkg;
    localparam int ADDR_W     = 12;
    localparam int REG_STRIDE = 4;
    localparam logic [ADDR_W-1:0] CTRL_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] STAT_BASE = 12'h150;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PULSE = 2'd1,
        LN_HELD  = 2'd2
    } line_state_e;

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int r);
        return CTRL_BASE + ADDR_W'(r * REG_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int r);
        return STAT_BASE + ADDR_W'(r * REG_STRIDE);
    endfunction
endpackage

// File: rtl/rgu_decode.sv
module rgu_decode
    import rgu_pkg::*;
#(
    parameter int NUM_LINES     = 64,
    parameter int LINES_PER_REG = 32
) (
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [LINES_PER_REG-1:0] bus_wdata,
    output logic [NUM_LINES-1:0]     line_wr,
    output logic [NUM_LINES-1:0]     line_val
);
    localparam int NUM_REGS = NUM_LINES / LINES_PER_REG;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit;
        assign hit = bus_we && (bus_addr == ctrl_addr(r));
        assign line_wr[r*LINES_PER_REG +: LINES_PER_REG]  = {LINES_PER_REG{hit}};
        assign line_val[r*LINES_PER_REG +: LINES_PER_REG] = bus_wdata;
    end
endmodule

// File: rtl/rgu_line.sv
module rgu_line
    import rgu_pkg::*;
#(
    parameter bit STICKY       = 1'b0,
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic val,
    output logic active,
    output logic held
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    line_state_e      st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State register and pulse counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LN_IDLE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (load)
                cnt <= CNT_W'(PULSE_CYCLES - 1);
            else if (st == LN_PULSE && !cnt_zero)
                cnt <= cnt - 1'b1;
        end
    end

    // Next state: ARM, RETRIGGER, EXPIRE, LATCH, RELEASE
    always_comb begin
        nxt  = st;
        load = 1'b0;
        unique case (st)
            LN_IDLE: begin
                if (wr && val) begin
                    nxt  = STICKY ? LN_HELD : LN_PULSE;
                    load = !STICKY;
                end
            end
            LN_PULSE: begin
                if (wr && val)
                    load = 1'b1;
                else if (cnt_zero)
                    nxt = LN_IDLE;
            end
            LN_HELD: begin
                if (wr && !val)
                    nxt = LN_IDLE;
            end
            default: nxt = LN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        active = (st != LN_IDLE);
        held   = (st == LN_HELD);
    end
endmodule

// File: rtl/rgu_readback.sv
module rgu_readback
    import rgu_pkg::*;
#(
    parameter int NUM_LINES     = 64,
    parameter int LINES_PER_REG = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_re,
    input  logic [NUM_LINES-1:0]     active,
    input  logic [NUM_LINES-1:0]     held,
    output logic [LINES_PER_REG-1:0] bus_rdata
);
    localparam int NUM_REGS = NUM_LINES / LINES_PER_REG;

    logic [LINES_PER_REG-1:0] rd_nxt;

    always_comb begin
        rd_nxt = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_addr == ctrl_addr(r))
                rd_nxt = held[r*LINES_PER_REG +: LINES_PER_REG];
            if (bus_addr == stat_addr(r))
                rd_nxt = ~active[r*LINES_PER_REG +: LINES_PER_REG];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_re ? rd_nxt : '0;
    end
endmodule

// File: rtl/rst_line_gen.sv
module rst_line_gen
    import rgu_pkg::*;
#(
    parameter int                  NUM_LINES     = 64,
    parameter int                  LINES_PER_REG = 32,
    parameter int                  PULSE_CYCLES  = 16,
    parameter logic [NUM_LINES-1:0] STICKY_MASK  = (64'd1 << 12) | (64'd1 << 56)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [LINES_PER_REG-1:0] bus_wdata,
    input  logic                     bus_re,
    output logic [LINES_PER_REG-1:0] bus_rdata,
    output logic [NUM_LINES-1:0]     rst_out
);
    logic [NUM_LINES-1:0] line_wr;
    logic [NUM_LINES-1:0] line_val;
    logic [NUM_LINES-1:0] line_held;

    rgu_decode #(
        .NUM_LINES    (NUM_LINES),
        .LINES_PER_REG(LINES_PER_REG)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .line_wr  (line_wr),
        .line_val (line_val)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        rgu_line #(
            .STICKY      (STICKY_MASK[i]),
            .PULSE_CYCLES(PULSE_CYCLES)
        ) u_line (
            .clk   (clk),
            .rst   (rst),
            .wr    (line_wr[i]),
            .val   (line_val[i]),
            .active(rst_out[i]),
            .held  (line_held[i])
        );
    end

    rgu_readback #(
        .NUM_LINES    (NUM_LINES),
        .LINES_PER_REG(LINES_PER_REG)
    ) u_readback (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_re   (bus_re),
        .active   (rst_out),
        .held     (line_held),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/rgu_checker.sv
module rgu_checker
    import rgu_pkg::*;
#(
    parameter int                   NUM_LINES     = 64,
    parameter int                   LINES_PER_REG = 32,
    parameter int                   PULSE_CYCLES  = 16,
    parameter logic [NUM_LINES-1:0] STICKY_MASK   = '0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_we,
    input logic [LINES_PER_REG-1:0] bus_wdata,
    input logic                     bus_re,
    input logic [LINES_PER_REG-1:0] bus_rdata,
    input logic [NUM_LINES-1:0]     rst_out
);
    localparam int NUM_REGS = NUM_LINES / LINES_PER_REG;
    localparam int RUN_W    = $clog2(PULSE_CYCLES + 1) + 1;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q)
            AST_RESET_QUIET: assert (rst_out == '0); // R1
    end

    AST_NO_RISE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((rst_out & ~$past(rst_out)) != '0) |-> $past(bus_we)); // R2

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sticky
        if (STICKY_MASK[i]) begin : g_chk
            AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (rst_out[i] && !(bus_we && bus_addr == ctrl_addr(i / LINES_PER_REG)))
                |=> rst_out[i]); // R6
            AST_STICKY_RELEASE: assert property (@(posedge clk) disable iff (rst)
                (bus_we && bus_addr == ctrl_addr(i / LINES_PER_REG) && !bus_wdata[i % LINES_PER_REG])
                |=> !rst_out[i]); // R7
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_stat
        AST_STATUS_INVERTED: assert property (@(posedge clk) disable iff (rst)
            ($past(bus_re && bus_addr == stat_addr(r)) && !$past(rst))
            |-> (bus_rdata == ~$past(rst_out[r*LINES_PER_REG +: LINES_PER_REG]))); // R8
    end

    if (!STICKY_MASK[0]) begin : g_run
        logic [RUN_W-1:0] run_cnt;
        logic             hit0;
        assign hit0 = bus_we && bus_addr == ctrl_addr(0) && bus_wdata[0];
        always_ff @(posedge clk) begin
            if (rst || hit0 || !rst_out[0])
                run_cnt <= '0;
            else
                run_cnt <= run_cnt + 1'b1;
        end
        AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
            rst_out[0] |-> (run_cnt < RUN_W'(PULSE_CYCLES))); // R4
    end
endmodule

bind rst_line_gen rgu_checker #(
    .NUM_LINES    (NUM_LINES),
    .LINES_PER_REG(LINES_PER_REG),
    .PULSE_CYCLES (PULSE_CYCLES),
    .STICKY_MASK  (STICKY_MASK)
) u_rgu_checker (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .rst_out  (rst_out)
);

// File: tb/tb_rst_line_gen.sv
`timescale 1ns/1ps
module tb_rst_line_gen;
    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic [63:0] rst_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    rst_line_gen dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .rst_out(rst_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: returns at the falling edge after the sampling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs after reset", rst_out, 64'h0);
        rd(12'h150, d); chk("R1 status0 after reset", {32'h0, d}, {32'h0, 32'hFFFF_FFFF});
        rd(12'h154, d); chk("R1 status1 after reset", {32'h0, d}, {32'h0, 32'hFFFF_FFFF});
    endtask

    task automatic t_pulse(input int n);
        logic [63:0] m;
        m = 64'd1 << n;
        wr(n < 32 ? 12'h100 : 12'h104, 32'd1 << (n % 32));
        chk($sformatf("R2 line %0d asserted", n), rst_out, m);
        repeat (PULSE - 1) @(negedge clk);
        chk($sformatf("R4 line %0d last cycle", n), rst_out, m);
        @(negedge clk);
        chk($sformatf("R4 line %0d released", n), rst_out, 64'h0);
    endtask

    task automatic t_zero_write();
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);
        chk("R3 zero write on idle", rst_out, 64'h0);
        wr(12'h100, 32'h80);                  // line 7, edge E
        repeat (4) @(negedge clk);
        wr(12'h100, 32'h0);                   // edge E+5
        chk("R3 zero write keeps pulse", rst_out, 64'h80);
        repeat (10) @(negedge clk);           // after E+15
        chk("R3 pulse length unchanged", rst_out, 64'h80);
        @(negedge clk);
        chk("R3 release on schedule", rst_out, 64'h0);
    endtask

    task automatic t_restart();
        wr(12'h100, 32'h8);                   // line 3
        repeat (10) @(negedge clk);
        wr(12'h100, 32'h8);                   // retrigger
        repeat (PULSE - 1) @(negedge clk);
        chk("R5 retrigger extends pulse", rst_out, 64'h8);
        @(negedge clk);
        chk("R5 release after restart", rst_out, 64'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(12'h100, 32'h1000);                // line 12
        repeat (3 * PULSE) @(negedge clk);
        chk("R6 line 12 held", rst_out, 64'h1000);
        rd(12'h100, d); chk("R9 ctrl0 held bit", {32'h0, d}, 64'h1000);
        rd(12'h150, d); chk("R8 status0 active-low", {32'h0, d}, {32'h0, ~32'h1000});
        wr(12'h100, 32'h1002);                // line 1 pulses, 12 stays
        rd(12'h100, d); chk("R9 ctrl0 hides pulse line", {32'h0, d}, 64'h1000);
        repeat (PULSE + 4) @(negedge clk);
        chk("R7 write of 1 keeps held line", rst_out, 64'h1000);
        wr(12'h100, 32'h0);
        chk("R7 zero write releases line 12", rst_out, 64'h0);
        wr(12'h104, 32'h0100_0000);           // line 56
        repeat (2 * PULSE) @(negedge clk);
        chk("R6 line 56 held", rst_out, 64'd1 << 56);
        rd(12'h104, d); chk("R9 ctrl1 held bit", {32'h0, d}, 64'h0100_0000);
        rd(12'h154, d); chk("R8 status1 active-low", {32'h0, d}, {32'h0, ~32'h0100_0000});
        wr(12'h104, 32'h0);
        chk("R7 zero write releases line 56", rst_out, 64'h0);
    endtask

    task automatic t_status_pulse();
        logic [31:0] d;
        wr(12'h104, 32'h2);                   // line 33
        rd(12'h154, d); chk("R8 status during pulse", {32'h0, d}, {32'h0, ~32'h2});
        rd(12'h104, d); chk("R9 ctrl1 pulse bit reads 0", {32'h0, d}, 64'h0);
        repeat (PULSE) @(negedge clk);
        rd(12'h154, d); chk("R8 status after pulse", {32'h0, d}, {32'h0, 32'hFFFF_FFFF});
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(12'h108, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h150, 32'hFFFF_FFFF);
        chk("R10 unmapped writes ignored", rst_out, 64'h0);
        rd(12'h108, d); chk("R10 unmapped read 0x108", {32'h0, d}, 64'h0);
        rd(12'h0FC, d); chk("R10 unmapped read 0x0FC", {32'h0, d}, 64'h0);
        @(negedge clk);
        chk("R10 rdata idle without read", {32'h0, bus_rdata}, 64'h0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pulse(0);
        t_pulse(31);
        t_pulse(32);
        t_pulse(63);
        t_zero_write();
        t_restart();
        t_sticky();
        t_status_pulse();
        t_unmapped();
        wr(12'h100, 32'h1001);                // line 0 pulse, line 12 held
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears all lines", rst_out, 64'h0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule